// File: doc/BRIEF.md
# Layer Sequencer with Alternating Feature Buffers

This block is the control unit of a small convolutional inference engine. The host first loads a table that gives each of the seven layers its input size, kernel size, input depth, output depth and kind (convolution or max-pool). It then writes a start bit. From that point the sequencer runs the layers in order. For each output element of a layer it presents one request to the arithmetic engine. A request carries the engine mode, the read address of the window origin in the source feature buffer, the write address in the destination buffer, and the weight and bias addresses. The engine does the window arithmetic itself and returns its result in the same cycle.

Two intermediate feature buffers swap roles at every layer boundary. The image sits in buffer A, so layer 0 reads A and writes B, layer 1 reads B and writes A, and so on. Fully connected layers are handled as 1x1 convolutions, with input size and kernel size both 1 and the vector length in the input-depth field. During the last layer the sequencer keeps a running signed maximum of the engine results. When it finishes, it reports the index of the winning class, raises an interrupt that stays set until the host clears it, and holds a count of the cycles the inference took.

States: S_IDLE waits for a start. S_LOAD latches the current layer's dimensions. S_RUN issues one output request per cycle. S_NEXT advances the weight and bias offsets and swaps the buffers. S_DONE latches the class and sets the interrupt. Transitions: S_IDLE to S_LOAD on a start write; S_LOAD to S_RUN always; S_RUN to S_NEXT after the last output of the layer; S_NEXT to S_LOAD while layers remain; S_NEXT to S_DONE after the final layer; S_DONE to S_IDLE always.

Top module: `lyr_seq_top`

## Requirements
- R1: After reset, busy, irq, out_valid and cycle_cnt are all 0.
- R2: A write of bit 0 to the control register at address 29, while idle, starts an inference, and busy is 1 from the next cycle. A start write while busy has no effect on the request stream, the cycle count or the result.
- R3: rd_buf_sel equals the parity of the current layer index (0 = buffer A, which holds the image), and writes go to the other buffer, so the roles swap at every layer.
- R4: A layer issues its outputs on consecutive out_valid cycles in channel, row, column order, with wr_addr counting 0, 1, 2, and so on. A convolution layer has (n-k+1) squared outputs per channel and a pool layer has (n/2) squared, with d channels in both cases.
- R5: For output (c,r,x), rd_addr is c*n*n + r*n + x for a convolution layer and c*n*n + 2r*n + 2x for a pool layer.
- R6: wt_addr is the layer's weight offset plus c*k*k*p, and bias_addr is the layer's bias offset plus c. Both offsets start at 0 and, after each convolution layer, grow by k*k*p*d and d. Pool layers leave them unchanged.
- R7: eng_mode is 1 for pool layers, 2 for the last layer and 0 for the other convolution layers.
- R8: class_idx is the 4-bit ordinal of the largest last-layer result, compared as signed numbers. On a tie the lowest ordinal wins.
- R9: irq rises when the last layer completes, while busy falls, and it stays 1 until a write of bit 1 to address 29.
- R10: At completion, cycle_cnt equals the number of non-idle cycles, which is the sum over layers of (outputs + 2), plus 1.
- R11: Register map: address 4L+f writes layer L's field f (0 = input size n, 1 = kernel k, 2 = input depth p, 3 = output depth d). Address 28 holds the pool mask, one bit per layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CA_W | Register address |
| cfg_wdata | input | 8 | Register write data |
| eng_result | input | RW | Signed engine result for the current request |
| busy | output | 1 | Inference in progress |
| irq | output | 1 | Completion interrupt, held until cleared |
| class_idx | output | CLS_W | Winning class index |
| cycle_cnt | output | CNT_W | Cycles used by the last inference |
| out_valid | output | 1 | An engine request is present this cycle |
| eng_mode | output | 2 | Engine mode for the current layer |
| rd_buf_sel | output | 1 | Source feature buffer (0 = A, 1 = B) |
| rd_addr | output | IA_W | Window origin in the source buffer |
| wr_addr | output | IA_W | Destination address for the result |
| wt_addr | output | WA_W | Base address of the kernel in weight RAM |
| bias_addr | output | BA_W | Bias RAM address |

## Verification
The bench runs the full seven-layer table, where pool strides, deep kernels and the fully connected layers all change the address formulas, and several random small tables that mix the pool and convolution kinds. These random tables show whether the bounds are really read from the register bank. For the last layer the engine results are random, all equal, tied maxima at two inner ordinals, or a most-negative value that would win under unsigned comparison. These patterns separate signed comparison and lowest-index tie breaking from wrong variants. One run writes a start in the middle of the inference, and the unchanged request stream and cycle count show that the write was ignored.

// File: rtl/lyr_seq_pkg.sv
package lyr_seq_pkg;
    localparam int DIM_W = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_RUN, S_NEXT, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        EM_CONV_RELU = 2'd0,
        EM_POOL      = 2'd1,
        EM_CONV_LIN  = 2'd2
    } eng_mode_t;

    typedef struct packed {
        logic [DIM_W-1:0] n;
        logic [DIM_W-1:0] k;
        logic [DIM_W-1:0] p;
        logic [DIM_W-1:0] d;
    } layer_dim_t;
endpackage

// File: rtl/lyr_seq_regs.sv
module lyr_seq_regs
    import lyr_seq_pkg::*;
#(
    parameter int LAYERS = 7,
    parameter int CA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [DIM_W-1:0]  cfg_wdata,
    output layer_dim_t        dims [LAYERS],
    output logic [LAYERS-1:0] pool_mask,
    output logic              start_req,
    output logic              irq_clr
);
    localparam logic [CA_W-1:0] POOL_A = CA_W'(4*LAYERS);
    localparam logic [CA_W-1:0] CTRL_A = CA_W'(4*LAYERS+1);

    for (genvar g = 0; g < LAYERS; g++) begin : g_lyr
        localparam logic [CA_W-1:0] BASE = CA_W'(4*g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dims[g] <= '0;
            end else if (cfg_we && cfg_addr[CA_W-1:2] == BASE[CA_W-1:2]) begin
                unique case (cfg_addr[1:0])
                    2'd0: dims[g].n <= cfg_wdata;
                    2'd1: dims[g].k <= cfg_wdata;
                    2'd2: dims[g].p <= cfg_wdata;
                    2'd3: dims[g].d <= cfg_wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pool_mask <= '0;
        else if (cfg_we && cfg_addr == POOL_A)
            pool_mask <= cfg_wdata[LAYERS-1:0];
    end

    assign start_req = cfg_we && (cfg_addr == CTRL_A) && cfg_wdata[0];
    assign irq_clr   = cfg_we && (cfg_addr == CTRL_A) && cfg_wdata[1];
endmodule

// File: rtl/lyr_seq_agen.sv
module lyr_seq_agen
    import lyr_seq_pkg::*;
#(
    parameter int IA_W = 16,
    parameter int WA_W = 17,
    parameter int BA_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            load,
    input  logic            adv,
    input  logic            nxt,
    input  layer_dim_t      dim,
    input  logic            is_pool,
    output logic [IA_W-1:0] rd_addr,
    output logic [IA_W-1:0] wr_addr,
    output logic [WA_W-1:0] wt_addr,
    output logic [BA_W-1:0] bias_addr,
    output logic            last_out
);
    logic [DIM_W-1:0] n_r, m_r, d_r, col, row, ch;
    logic             pool_r;
    logic [IA_W-1:0]  plane, ord;
    logic [WA_W-1:0]  kkp, wt_off;
    logic [BA_W-1:0]  b_off;
    logic             col_end, row_end;

    assign col_end  = (col == m_r - DIM_W'(1));
    assign row_end  = (row == m_r - DIM_W'(1));
    assign last_out = col_end && row_end && (ch == d_r - DIM_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_r <= '0; m_r <= '0; d_r <= '0; pool_r <= 1'b0;
            plane <= '0; kkp <= '0;
            col <= '0; row <= '0; ch <= '0; ord <= '0;
            wt_off <= '0; b_off <= '0;
        end else begin
            if (init) begin
                wt_off <= '0;
                b_off  <= '0;
            end
            if (load) begin
                n_r    <= dim.n;
                d_r    <= dim.d;
                pool_r <= is_pool;
                m_r    <= is_pool ? (dim.n >> 1) : (dim.n - dim.k + DIM_W'(1));
                plane  <= IA_W'(dim.n) * IA_W'(dim.n);
                kkp    <= WA_W'(dim.k) * WA_W'(dim.k) * WA_W'(dim.p);
                col <= '0; row <= '0; ch <= '0; ord <= '0;
            end
            if (adv) begin
                ord <= ord + IA_W'(1);
                if (col_end) begin
                    col <= '0;
                    if (row_end) begin
                        row <= '0;
                        ch  <= ch + DIM_W'(1);
                    end else begin
                        row <= row + DIM_W'(1);
                    end
                end else begin
                    col <= col + DIM_W'(1);
                end
            end
            if (nxt && !pool_r) begin
                wt_off <= wt_off + kkp * WA_W'(d_r);
                b_off  <= b_off + BA_W'(d_r);
            end
        end
    end

    assign rd_addr   = IA_W'(ch) * plane
                     + (IA_W'(row) << pool_r) * IA_W'(n_r)
                     + (IA_W'(col) << pool_r);
    assign wr_addr   = ord;
    assign wt_addr   = wt_off + WA_W'(ch) * kkp;
    assign bias_addr = b_off + BA_W'(ch);
endmodule

// File: rtl/lyr_seq_argmax.sv
module lyr_seq_argmax #(
    parameter int RW    = 16,
    parameter int CLS_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 valid,
    input  logic signed [RW-1:0] res,
    input  logic [CLS_W-1:0]     idx_in,
    output logic [CLS_W-1:0]     best_idx
);
    logic                 seen;
    logic signed [RW-1:0] best;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            best     <= '0;
            best_idx <= '0;
        end else if (clr) begin
            seen     <= 1'b0;
            best_idx <= '0;
        end else if (valid && (!seen || res > best)) begin
            seen     <= 1'b1;
            best     <= res;
            best_idx <= idx_in;
        end
    end
endmodule

// File: rtl/lyr_seq_top.sv
module lyr_seq_top
    import lyr_seq_pkg::*;
#(
    parameter int LAYERS = 7,
    parameter int IA_W   = 16,
    parameter int WA_W   = 17,
    parameter int BA_W   = 10,
    parameter int RW     = 16,
    parameter int CNT_W  = 32,
    parameter int CLS_W  = 4,
    parameter int CA_W   = $clog2(4*LAYERS+2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CA_W-1:0]      cfg_addr,
    input  logic [DIM_W-1:0]     cfg_wdata,
    input  logic signed [RW-1:0] eng_result,
    output logic                 busy,
    output logic                 irq,
    output logic [CLS_W-1:0]     class_idx,
    output logic [CNT_W-1:0]     cycle_cnt,
    output logic                 out_valid,
    output logic [1:0]           eng_mode,
    output logic                 rd_buf_sel,
    output logic [IA_W-1:0]      rd_addr,
    output logic [IA_W-1:0]      wr_addr,
    output logic [WA_W-1:0]      wt_addr,
    output logic [BA_W-1:0]      bias_addr
);
    localparam int LY_W = $clog2(LAYERS);
    localparam logic [LY_W-1:0] LAST_L = LY_W'(LAYERS-1);

    seq_state_t        st_q, st_d;
    logic [LY_W-1:0]   lyr_q;
    layer_dim_t        dims [LAYERS];
    logic [LAYERS-1:0] pool_mask;
    logic              start_req, irq_clr, last_out, go;
    logic [CLS_W-1:0]  best_idx;

    assign go = start_req && (st_q == S_IDLE);

    lyr_seq_regs #(.LAYERS(LAYERS), .CA_W(CA_W)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .dims, .pool_mask, .start_req, .irq_clr
    );

    lyr_seq_agen #(.IA_W(IA_W), .WA_W(WA_W), .BA_W(BA_W)) u_agen (
        .clk, .rst_n,
        .init(go), .load(st_q == S_LOAD), .adv(st_q == S_RUN), .nxt(st_q == S_NEXT),
        .dim(dims[lyr_q]), .is_pool(pool_mask[lyr_q]),
        .rd_addr, .wr_addr, .wt_addr, .bias_addr, .last_out
    );

    lyr_seq_argmax #(.RW(RW), .CLS_W(CLS_W)) u_amax (
        .clk, .rst_n, .clr(go),
        .valid(out_valid && lyr_q == LAST_L),
        .res(eng_result), .idx_in(wr_addr[CLS_W-1:0]), .best_idx
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (go) st_d = S_LOAD;
            S_LOAD: st_d = S_RUN;
            S_RUN:  if (last_out) st_d = S_NEXT;
            S_NEXT: st_d = (lyr_q == LAST_L) ? S_DONE : S_LOAD;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lyr_q     <= '0;
            cycle_cnt <= '0;
            irq       <= 1'b0;
            class_idx <= '0;
        end else begin
            if (go)
                lyr_q <= '0;
            else if (st_q == S_NEXT && lyr_q != LAST_L)
                lyr_q <= lyr_q + LY_W'(1);
            if (go)
                cycle_cnt <= '0;
            else if (st_q != S_IDLE)
                cycle_cnt <= cycle_cnt + CNT_W'(1);
            if (st_q == S_DONE) begin
                irq       <= 1'b1;
                class_idx <= best_idx;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    always_comb begin
        busy       = (st_q != S_IDLE);
        out_valid  = (st_q == S_RUN);
        rd_buf_sel = lyr_q[0];
        if (pool_mask[lyr_q])
            eng_mode = EM_POOL;
        else if (lyr_q == LAST_L)
            eng_mode = EM_CONV_LIN;
        else
            eng_mode = EM_CONV_RELU;
    end
endmodule

// File: rtl/lyr_seq_chk.sv
module lyr_seq_chk #(
    parameter int CA_W   = 5,
    parameter int IA_W   = 16,
    parameter int CNT_W  = 32,
    parameter int CTRL_A = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CA_W-1:0]  cfg_addr,
    input logic             clr_bit,
    input logic             busy,
    input logic             irq,
    input logic             out_valid,
    input logic             rd_buf_sel,
    input logic [IA_W-1:0]  wr_addr,
    input logic [CNT_W-1:0] cycle_cnt
);
    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_addr == CA_W'(CTRL_A)) && clr_bit;

    assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (wr_addr == $past(wr_addr) + IA_W'(1)));

    assert_sel_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(rd_buf_sel));

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_irq_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!busy && $past(busy)));
endmodule

bind lyr_seq_top lyr_seq_chk #(
    .CA_W(CA_W), .IA_W(IA_W), .CNT_W(CNT_W), .CTRL_A(4*LAYERS+1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .clr_bit(cfg_wdata[1]), .busy(busy), .irq(irq), .out_valid(out_valid),
    .rd_buf_sel(rd_buf_sel), .wr_addr(wr_addr), .cycle_cnt(cycle_cnt)
);

// File: tb/lyr_seq_top_tb_top.sv
module lyr_seq_top_tb_top;
    localparam int CA_W = 5;
    localparam int CTRL = 29;
    localparam int POOLA = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [CA_W-1:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] eng_result = '0;
    logic        busy, irq, out_valid, rd_buf_sel;
    logic [3:0]  class_idx;
    logic [31:0] cycle_cnt;
    logic [1:0]  eng_mode;
    logic [15:0] rd_addr, wr_addr;
    logic [16:0] wt_addr;
    logic [9:0]  bias_addr;

    int nchecks = 0;
    int nfails  = 0;
    bit finished = 1'b0;
    int tn[7], tk[7], tp[7], td[7];
    bit tpool[7];

    always #2 clk = ~clk;

    lyr_seq_top dut_i (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .eng_result,
        .busy, .irq, .class_idx, .cycle_cnt, .out_valid, .eng_mode,
        .rd_buf_sel, .rd_addr, .wr_addr, .wt_addr, .bias_addr
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CA_W'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int out_dim(input int L);
        return tpool[L] ? tn[L] / 2 : tn[L] - tk[L] + 1;
    endfunction

    function automatic int last_val(input int mode, input int j);
        case (mode)
            1: return -7;
            2: return (j == 3 || j == 7) ? 100 : -(j + 1) * 50;
            3: return (j == 0) ? -32768 : j;
            default: return int'($signed(16'($urandom)));
        endcase
    endfunction

    task automatic load_table();
        int mask = 0;
        for (int L = 0; L < 7; L++) begin
            cfg_wr(4*L + 0, tn[L]);  // R11 field order
            cfg_wr(4*L + 1, tk[L]);
            cfg_wr(4*L + 2, tp[L]);
            cfg_wr(4*L + 3, td[L]);
            if (tpool[L]) mask |= (1 << L);
        end
        cfg_wr(POOLA, mask);
    endtask

    task automatic set_lenet();
        tn = '{28, 24, 12, 8, 4, 1, 1};
        tk = '{5, 1, 5, 1, 4, 1, 1};
        tp = '{1, 6, 6, 16, 16, 120, 84};
        td = '{6, 6, 16, 16, 120, 84, 10};
        tpool = '{0, 1, 0, 1, 0, 0, 0};
    endtask

    task automatic set_random();
        for (int L = 0; L < 6; L++) begin
            tpool[L] = 1'($urandom % 2);
            if (tpool[L]) begin
                tn[L] = 2 * (1 + int'($urandom % 3)); tk[L] = 1;
            end else begin
                tn[L] = 1 + int'($urandom % 5); tk[L] = 1 + int'($urandom % tn[L]);
            end
            tp[L] = 1 + int'($urandom % 3);
            td[L] = 1 + int'($urandom % 3);
        end
        tpool[6] = 1'b0;
        tn[6] = 1 + int'($urandom % 3); tk[6] = tn[6];
        tp[6] = 1 + int'($urandom % 3);
        td[6] = 2 + int'($urandom % 11);
    endtask

    task automatic run(input int mode, input bit poke);
        int woff = 0, boff = 0, best = 0, bidx = 0, ecnt = 1, waits = 0;
        bit seen = 0;
        cfg_wr(CTRL, 1);
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        for (int L = 0; L < 7; L++) begin
            int m = out_dim(L);
            int o = 0;
            ecnt += m * m * td[L] + 2;
            for (int c = 0; c < td[L]; c++)
                for (int r = 0; r < m; r++)
                    for (int x = 0; x < m; x++) begin
                        int ea, em, v;
                        @(negedge clk);
                        cfg_we = 1'b0;
                        waits = 0;
                        while (!out_valid && waits < 20) begin
                            @(negedge clk); waits++;
                        end
                        chk(out_valid === 1'b1, "R4 request present", out_valid, 1);
                        chk(wr_addr == 16'(o), "R4 wr_addr ordinal", wr_addr, o);
                        ea = tpool[L] ? c*tn[L]*tn[L] + 2*r*tn[L] + 2*x
                                      : c*tn[L]*tn[L] + r*tn[L] + x;
                        chk(rd_addr == 16'(ea), "R5 rd_addr", rd_addr, ea);
                        chk(rd_buf_sel == 1'(L % 2), "R3 buffer select", rd_buf_sel, L % 2);
                        em = tpool[L] ? 1 : (L == 6 ? 2 : 0);
                        chk(eng_mode == 2'(em), "R7 eng_mode", eng_mode, em);
                        if (!tpool[L]) begin
                            ea = woff + c * tk[L] * tk[L] * tp[L];
                            chk(wt_addr == 17'(ea), "R6 wt_addr", wt_addr, ea);
                            chk(bias_addr == 10'(boff + c), "R6 bias_addr", bias_addr, boff + c);
                        end
                        v = (L == 6) ? last_val(mode, o) : int'($urandom);
                        eng_result = 16'(v);
                        if (L == 6 && (!seen || v > best)) begin
                            seen = 1; best = v; bidx = o;
                        end
                        if (poke && L == 1 && o == 0) begin
                            cfg_we = 1'b1; cfg_addr = CA_W'(CTRL); cfg_wdata = 8'd1;  // R2 start while busy
                        end
                        o++;
                    end
            if (!tpool[L]) begin
                woff += tk[L] * tk[L] * tp[L] * td[L];
                boff += td[L];
            end
        end
        waits = 0;
        while (!irq && waits < 10) begin
            @(negedge clk); waits++;
        end
        chk(irq === 1'b1, "R9 irq raised", irq, 1);
        chk(busy === 1'b0, "R9 idle at irq", busy, 0);
        chk(class_idx == 4'(bidx), "R8 class_idx", class_idx, bidx);
        chk(cycle_cnt == 32'(ecnt), "R10 cycle_cnt", cycle_cnt, ecnt);
        repeat (3) @(negedge clk);
        chk(irq === 1'b1, "R9 irq held", irq, 1);
        chk(cycle_cnt == 32'(ecnt), "R10 count held", cycle_cnt, ecnt);
        cfg_wr(CTRL, 2);
        chk(irq === 1'b0, "R9 irq cleared", irq, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && irq === 1'b0, "R1 reset flags", {busy, irq}, 0);
        chk(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(cycle_cnt == 32'd0, "R1 reset count", cycle_cnt, 0);
        rst_n = 1'b1;
        set_lenet();
        load_table();
        run(0, 1'b1);
        run(1, 1'b0);
        run(2, 1'b0);
        run(3, 1'b0);
        for (int i = 0; i < 8; i++) begin
            set_random();
            load_table();
            run(i % 4, i == 2);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchecks++; nfails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end
endmodule